// File: doc/BRIEF.md
# Write-Triggered Cartridge ROM Bank Mapper

This block sits between a console processor bus and a 2MB cartridge ROM. It turns each access in the 1MB cartridge window into a 21-bit physical ROM address. The lower 512K of the window always shows the same fixed part of the ROM. The upper 512K of the window shows one of four 512K banks.

Software picks the visible bank by writing to one of four trigger addresses. The trigger addresses sit inside the fixed region. The bank number comes from the two lowest address bits of that write. The data value of the write is ignored. Reads at the trigger addresses return ordinary fixed-region ROM data.

The ROM address and the ROM read enable are registered. Both appear one clock after the bus cycle that caused them.

Top module: `cart_bank_mapper`

## Requirements
- R1: While `rst` is high, the bank register is cleared to 0. On the cycle after reset, `rom_rd` is 0 and `rom_addr` is 0.
- R2: A read (`cart_ce_n`=0, `bus_wr`=0) with `bus_addr[19]`=0 gives `rom_addr` = {2'b00, `bus_addr[18:0]`} one cycle later.
- R3: A read with `bus_addr[19]`=1 gives `rom_addr` = {bank, `bus_addr[18:0]`} one cycle later. The bank used is the value held in the register during the read cycle.
- R4: A write (`cart_ce_n`=0, `bus_wr`=1) to an address whose `bus_addr[19:2]` equals 18'h007FC (addresses 0x01FF0 to 0x01FF3) loads the bank with `bus_addr[1:0]`. The new bank is in force for reads in the next cycle.
- R5: The value on `bus_wdata` during a trigger write has no effect on the bank chosen.
- R6: Writes to any other address leave the bank unchanged. A trigger-address write while `cart_ce_n`=1 also leaves the bank unchanged.
- R7: A read at 0x01FF0 to 0x01FF3 gives the fixed-region address {2'b00, `bus_addr[18:0]`} and does not change the bank.
- R8: `rom_rd` is 1 in the cycle after a cycle with `cart_ce_n`=0 and `bus_wr`=0. It is 0 after any other cycle, including every write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cart_ce_n | input | 1 | Cartridge chip enable, active low |
| bus_addr | input | 20 | Address within the 1MB cartridge window |
| bus_wr | input | 1 | Write strobe, active high, one cycle per write |
| bus_wdata | input | 8 | Write data, ignored by the mapper |
| rom_addr | output | 21 | Registered physical ROM address |
| rom_rd | output | 1 | Registered ROM read enable, active high |

## Verification
Two things can happen in the same clock cycle: a bank-register update and an address translation. A trigger write is applied, and a banked-window read is issued in the very next cycle. The check is that this read already uses the new bank, while the write cycle itself produces no read enable. Trigger writes with nonzero data, near-miss addresses and a deasserted chip enable are mixed in. A scoreboard model compares each registered output against its own bank copy.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;
  parameter int WIN_AW  = 20;          // cartridge window address width
  parameter int BANK_W  = 2;           // bank number width
  parameter int DATA_W  = 8;           // bus data width
  parameter logic [WIN_AW-1:0] TRIG_BASE = 20'h01FF0;
  localparam int ROM_AW = WIN_AW - 1 + BANK_W;
endpackage

// File: rtl/cart_bank_select.sv
module cart_bank_select #(
  parameter int WIN_AW = cart_bank_pkg::WIN_AW,
  parameter int BANK_W = cart_bank_pkg::BANK_W,
  parameter int DATA_W = cart_bank_pkg::DATA_W,
  parameter logic [WIN_AW-1:0] TRIG_BASE = cart_bank_pkg::TRIG_BASE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr,
  input  logic [WIN_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [BANK_W-1:0] bank
);
  logic hit;
  logic trig;

  assign hit  = (addr[WIN_AW-1:BANK_W] == TRIG_BASE[WIN_AW-1:BANK_W]);
  assign trig = sel && wr && hit;

  always_ff @(posedge clk) begin
    if (rst)       bank <= '0;
    else if (trig) bank <= addr[BANK_W-1:0];
  end

  // R4: a trigger write loads the low address bits
  p_bank_load_r4: assert property (@(posedge clk) disable iff (rst)
    trig |=> bank == $past(addr[BANK_W-1:0]));
  // R5: a nonzero data value still selects by address only
  p_data_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    (trig && wdata != '0) |=> bank == $past(addr[BANK_W-1:0]));
  // R6: no trigger, no change
  p_bank_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !trig |=> $stable(bank));
endmodule

// File: rtl/cart_addr_xlate.sv
module cart_addr_xlate #(
  parameter int WIN_AW = cart_bank_pkg::WIN_AW,
  parameter int BANK_W = cart_bank_pkg::BANK_W,
  localparam int ROM_AW = WIN_AW - 1 + BANK_W
) (
  input  logic [WIN_AW-1:0] addr,
  input  logic [BANK_W-1:0] bank,
  output logic [ROM_AW-1:0] phys
);
  localparam int OFF_W = WIN_AW - 1;

  always_comb begin
    if (addr[WIN_AW-1]) phys = {bank, addr[OFF_W-1:0]};
    else                phys = {{BANK_W{1'b0}}, addr[OFF_W-1:0]};
  end
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper #(
  parameter int WIN_AW = cart_bank_pkg::WIN_AW,
  parameter int BANK_W = cart_bank_pkg::BANK_W,
  parameter int DATA_W = cart_bank_pkg::DATA_W,
  parameter logic [WIN_AW-1:0] TRIG_BASE = cart_bank_pkg::TRIG_BASE,
  localparam int ROM_AW = WIN_AW - 1 + BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cart_ce_n,
  input  logic [WIN_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_rd
);
  localparam int OFF_W = WIN_AW - 1;

  logic              sel;
  logic [BANK_W-1:0] bank;
  logic [ROM_AW-1:0] phys;

  assign sel = !cart_ce_n;

  cart_bank_select #(
    .WIN_AW(WIN_AW), .BANK_W(BANK_W), .DATA_W(DATA_W), .TRIG_BASE(TRIG_BASE)
  ) u_sel (
    .clk(clk), .rst(rst), .sel(sel), .wr(bus_wr),
    .addr(bus_addr), .wdata(bus_wdata), .bank(bank)
  );

  cart_addr_xlate #(.WIN_AW(WIN_AW), .BANK_W(BANK_W)) u_xlate (
    .addr(bus_addr), .bank(bank), .phys(phys)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_addr <= '0;
      rom_rd   <= 1'b0;
    end else begin
      rom_addr <= phys;
      rom_rd   <= sel && !bus_wr;
    end
  end

  // R1: outputs cleared after reset
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (rom_rd == 1'b0 && rom_addr == '0));
  // R2: fixed half has zero bank bits
  p_fixed_r2: assert property (@(posedge clk) disable iff (rst)
    (sel && !bus_wr && !bus_addr[WIN_AW-1]) |=>
      (rom_addr[ROM_AW-1:OFF_W] == '0 && rom_addr[OFF_W-1:0] == $past(bus_addr[OFF_W-1:0])));
  // R3: upper half carries the bank
  p_banked_r3: assert property (@(posedge clk) disable iff (rst)
    (sel && !bus_wr && bus_addr[WIN_AW-1]) |=>
      rom_addr[ROM_AW-1:OFF_W] == $past(bank));
  // R8: read enable only after reads
  p_rd_read_r8: assert property (@(posedge clk) disable iff (rst)
    (sel && !bus_wr) |=> rom_rd);
  p_rd_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (!sel || bus_wr) |=> !rom_rd);
endmodule

// File: tb/cart_bank_mapper_test.sv
module cart_bank_mapper_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        cart_ce_n;
  logic [19:0] bus_addr;
  logic        bus_wr;
  logic [7:0]  bus_wdata;
  logic [20:0] rom_addr;
  logic        rom_rd;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [1:0]  mbank;
  logic [20:0] qa[$];
  bit          qr[$];
  bit          qc[$];
  string       qt[$];

  always #10 clk = ~clk;

  cart_bank_mapper uut (
    .clk(clk), .rst(rst), .cart_ce_n(cart_ce_n), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .rom_addr(rom_addr), .rom_rd(rom_rd)
  );

  task automatic chk(input bit ok, input string tag, input logic [20:0] act, input logic [20:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one bus cycle, pushes the expected registered result
  task automatic cyc(input bit ce_n, input logic [19:0] a, input bit wr,
                     input logic [7:0] d, input bit chk_a, input string tag);
    logic [20:0] ea;
    @(negedge clk);
    cart_ce_n = ce_n; bus_addr = a; bus_wr = wr; bus_wdata = d;
    ea = a[19] ? {mbank, a[18:0]} : {2'b00, a[18:0]};
    qa.push_back(ea);
    qr.push_back(!ce_n && !wr);
    qc.push_back(chk_a);
    qt.push_back(tag);
    if (!ce_n && wr && a[19:2] == 18'h007FC) mbank = a[1:0];
  endtask

  // monitor: pops one expectation per clock edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (qa.size() != 0) begin
        logic [20:0] ea; bit er; bit ec; string t;
        ea = qa.pop_front(); er = qr.pop_front(); ec = qc.pop_front(); t = qt.pop_front();
        chk(rom_rd == er, {t, " rd"}, {20'b0, rom_rd}, {20'b0, er});
        if (ec) chk(rom_addr == ea, {t, " addr"}, rom_addr, ea);
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cart_ce_n = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    mbank = 2'd0;
    repeat (3) @(posedge clk);
    #5;
    chk(rom_rd == 1'b0 && rom_addr == '0, "R1 reset", rom_addr, 21'h0);
    @(negedge clk); rst = 1'b0;

    cyc(0, 20'h00123, 0, 8'h00, 1, "R2 fixed read");
    cyc(0, 20'h7FFFF, 0, 8'h00, 1, "R2 fixed top");
    cyc(0, 20'h80000, 0, 8'h00, 1, "R3 bank0 base");
    cyc(0, 20'hFFFFF, 0, 8'h00, 1, "R3 bank0 top");
    cyc(0, 20'h01FF2, 1, 8'h00, 0, "R8 write no rd");
    cyc(0, 20'h80000, 0, 8'h00, 1, "R4 bank2 gives 100000");
    cyc(0, 20'h01FF2, 0, 8'h00, 1, "R7 trigger read");
    cyc(0, 20'h80000, 0, 8'h00, 1, "R7 bank kept after read");
    cyc(0, 20'h01FF1, 1, 8'hA5, 0, "R5 data write");
    cyc(0, 20'h80010, 0, 8'h00, 1, "R5 bank1 despite data");
    cyc(0, 20'h01FF4, 1, 8'h03, 0, "R6 near miss above");
    cyc(0, 20'h01FEF, 1, 8'h02, 0, "R6 near miss below");
    cyc(0, 20'h81FF3, 1, 8'h00, 0, "R6 upper alias");
    cyc(1, 20'h01FF3, 1, 8'h00, 0, "R6 ce high write");
    cyc(0, 20'hC0000, 0, 8'h00, 1, "R6 bank still 1");
    cyc(1, 20'h80000, 0, 8'h00, 0, "R8 ce high no rd");
    cyc(0, 20'h01FF3, 1, 8'hFF, 0, "R4 write bank3");
    cyc(0, 20'hABCDE, 0, 8'h00, 1, "R4 bank3 read");
    cyc(0, 20'h01FF0, 1, 8'h5A, 0, "R4 write bank0");
    cyc(0, 20'h80005, 0, 8'h00, 1, "R3 back to bank0");
    cyc(0, 20'h01FF0, 0, 8'h00, 1, "R7 read at base trigger");
    cyc(1, 20'h00000, 0, 8'h00, 0, "R8 idle");

    repeat (4) @(posedge clk);
    #5;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule